// File: doc/BRIEF.md
# Interleaved-pilot least-squares channel estimator with hold

This block produces uplink channel estimates for a group of users whose pilots occupy interleaved, non-overlapping subcarriers of one pilot symbol. Received samples arrive one subcarrier per beat, each with the known pilot value that was sent on that subcarrier. The owner of subcarrier k is user k mod NU. The block multiplies the conjugated pilot by the received sample to form a least-squares estimate for the owning user. Each user's estimate is then held constant over the subcarriers that user does not occupy. Every output beat carries one complex estimate for every user.

A symbol begins with a start-of-symbol beat. The pilot flag on that beat picks the mode for the whole symbol. In a pilot symbol, fresh estimates are computed and stored for every subcarrier. In a data symbol, the stored estimates of the latest pilot symbol are replayed subcarrier by subcarrier, so the estimates stay constant in time until the next pilot symbol. For the first NU subcarriers of a symbol, a user has not yet appeared. Those subcarriers carry the estimate from that user's first owned subcarrier.

Both edges are valid/ready streams. An input beat transfers when in_valid and in_ready are both high. An output beat transfers when out_valid and out_ready are both high. A stalled output holds all of its values. in_ready is high when the single input register is empty or is being drained in the same cycle, so it follows out_ready combinationally. NSC must be a multiple of NU.

Top module: `chest_ls_zoh`

## Requirements
- R1: Samples and pilots are signed 16-bit I/Q with 15 fraction bits. For received sample (yr, yi) and pilot (pr, pi), the estimate is re = sat((pr*yr + pi*yi + 2^14) >>> 15) and im = sat((pr*yi - pi*yr + 2^14) >>> 15), where sat clamps to [-32768, 32767].
- R2: Subcarrier k (k = 0 at the start-of-symbol beat) is owned by user (k mod NU). In a pilot symbol with k >= NU, the output for that user at k is the estimate computed from beat k.
- R3: In a pilot symbol, for k >= NU the output for user u is the estimate of the highest subcarrier j <= k with j mod NU = u.
- R4: For k < NU, in both pilot and data symbols, the output for user u is the estimate of subcarrier u of the latest pilot symbol.
- R5: In a data symbol, the output at subcarrier k equals what the latest pilot symbol produced at k. This holds for every later data symbol until the next pilot symbol.
- R6: After reset and before any pilot symbol has been received, every estimate output is zero.
- R7: Each accepted input beat yields exactly one output beat, in order. out_sc gives the beat's subcarrier index, which is 0 at start-of-symbol, steps by one per beat and wraps to 0 after NSC-1.
- R8: While out_valid is high and out_ready is low, out_valid, out_sc, out_re and out_im stay unchanged. in_ready is high only when the input register is empty or drains in that cycle.
- R9: In a pilot symbol, no output for subcarriers 0..NU-1 appears before the beat of subcarrier NU-1 has been accepted. Those NU outputs then follow one per ready cycle.
- R10: During reset, out_valid is low and in_ready is high.
- R11: in_pilot is sampled only on the start-of-symbol beat. On other beats it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_sop | input | 1 | Beat is subcarrier 0 of a new symbol |
| in_pilot | input | 1 | Symbol is a pilot symbol (sampled with in_sop) |
| in_rx_re | input | 16 | Received sample, real part |
| in_rx_im | input | 16 | Received sample, imaginary part |
| in_pil_re | input | 16 | Known pilot, real part |
| in_pil_im | input | 16 | Known pilot, imaginary part |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sc | output | clog2(NSC) | Subcarrier index of the output beat |
| out_re | output | 16*NU | Real parts, user u at bits [16u+15:16u] |
| out_im | output | 16*NU | Imaginary parts, user u at bits [16u+15:16u] |

## Verification
A wrong stored estimate stays invisible until its subcarrier comes up again. It then appears at the ports for exactly that user over a run of up to NU subcarriers, and again in every data symbol until the next pilot. For that reason the sweeps replay each pilot symbol in several data symbols and compare every user at every subcarrier. A slipped subcarrier or user counter shows at the very next output beat, as a wrong out_sc or as an estimate assigned to the wrong user. A mistake in the start-up burst of a pilot symbol shows in the first NU output beats, either as early output or as a missing beat.

// File: rtl/chest_pkg.sv
package chest_pkg;
  localparam int CW = 16;

  typedef struct packed {
    logic signed [CW-1:0] re;
    logic signed [CW-1:0] im;
  } cplx_t;
endpackage

// File: rtl/chest_conj_mul.sv
module chest_conj_mul
  import chest_pkg::*;
(
  input  cplx_t rx,
  input  cplx_t pil,
  output cplx_t ls
);
  localparam int SW = 2 * CW + 1;
  localparam logic signed [SW-1:0] HI  = SW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO  = ~HI;
  localparam logic signed [SW-1:0] RND = SW'(64'sd1 <<< (CW - 2));

  logic signed [2*CW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [SW-1:0]   acc_re, acc_im;

  function automatic logic signed [CW-1:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = (v + RND) >>> (CW - 1);
    if (t > HI)      return HI[CW-1:0];
    else if (t < LO) return LO[CW-1:0];
    else             return t[CW-1:0];
  endfunction

  always_comb begin
    p_rr   = $signed(pil.re) * $signed(rx.re);
    p_ii   = $signed(pil.im) * $signed(rx.im);
    p_ri   = $signed(pil.re) * $signed(rx.im);
    p_ir   = $signed(pil.im) * $signed(rx.re);
    acc_re = SW'(p_rr) + SW'(p_ii);
    acc_im = SW'(p_ri) - SW'(p_ir);
    ls.re  = rnd_sat(acc_re);
    ls.im  = rnd_sat(acc_im);
  end
endmodule

// File: rtl/chest_coeff_mem.sv
module chest_coeff_mem
  import chest_pkg::*;
#(
  parameter int NU  = 12,
  parameter int NSC = 300,
  parameter int IW  = $clog2(NSC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  cplx_t            wr_val,
  input  logic [IW-1:0]    rd_idx,
  output cplx_t            rd_val,
  output cplx_t [NU-1:0]   first_vec
);
  cplx_t mem [NSC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSC; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];

  for (genvar g = 0; g < NU; g++) begin : g_first
    assign first_vec[g] = mem[g];
  end
endmodule

// File: rtl/chest_zoh_out.sv
module chest_zoh_out
  import chest_pkg::*;
#(
  parameter int NU  = 12,
  parameter int NSC = 300,
  parameter int IW  = $clog2(NSC),
  parameter int UW  = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_v,
  input  logic            s1_pil,
  input  logic [IW-1:0]   s1_idx,
  input  logic [UW-1:0]   s1_user,
  input  cplx_t           s1_val,
  input  cplx_t [NU-1:0]  first_vec,
  output logic            s1_take,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IW-1:0]   out_sc,
  output cplx_t [NU-1:0]  out_est
);
  localparam int BW = (NU > 1) ? $clog2(NU) : 1;

  cplx_t [NU-1:0] hold;
  logic [BW-1:0]  bcnt;
  logic           adv;

  assign adv     = !out_valid || out_ready;
  assign s1_take = s1_v && adv && (bcnt == '0);
  assign out_est = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sc    <= '0;
      bcnt      <= '0;
      hold      <= '0;
    end else if (adv) begin
      if (bcnt != '0) begin
        out_valid <= 1'b1;
        out_sc    <= out_sc + IW'(1);
        bcnt      <= bcnt - BW'(1);
      end else if (s1_v) begin
        if (s1_pil) begin
          hold[s1_user] <= s1_val;
          if (s1_idx < IW'(NU - 1)) begin
            out_valid <= 1'b0;
          end else if (s1_idx == IW'(NU - 1)) begin
            out_valid <= 1'b1;
            out_sc    <= '0;
            bcnt      <= BW'(NU - 1);
          end else begin
            out_valid <= 1'b1;
            out_sc    <= s1_idx;
          end
        end else begin
          if (s1_idx == '0) hold <= first_vec;
          else              hold[s1_user] <= s1_val;
          out_valid <= 1'b1;
          out_sc    <= s1_idx;
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sc) && $stable(hold))); // R8

  AST_SC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_sc == '0 || out_sc == $past(out_sc) + IW'(1))); // R7

  AST_BURST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0) |-> out_valid); // R9
endmodule

// File: rtl/chest_ls_zoh.sv
module chest_ls_zoh
  import chest_pkg::*;
#(
  parameter int NU  = 12,
  parameter int NSC = 300
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic                    in_pilot,
  input  logic [CW-1:0]           in_rx_re,
  input  logic [CW-1:0]           in_rx_im,
  input  logic [CW-1:0]           in_pil_re,
  input  logic [CW-1:0]           in_pil_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [$clog2(NSC)-1:0]  out_sc,
  output logic [NU*CW-1:0]        out_re,
  output logic [NU*CW-1:0]        out_im
);
  localparam int IW = $clog2(NSC);
  localparam int UW = (NU > 1) ? $clog2(NU) : 1;

  cplx_t          rx_c, pil_c, ls_c, rd_c, s1_val;
  cplx_t [NU-1:0] first_vec, est;
  logic           s1_v, s1_pil, s1_take, accept, nmode;
  logic [IW-1:0]  s1_idx, nidx;
  logic [UW-1:0]  s1_user, nuser;

  assign rx_c   = '{re: in_rx_re, im: in_rx_im};
  assign pil_c  = '{re: in_pil_re, im: in_pil_im};
  assign in_ready = !s1_v || s1_take;
  assign accept   = in_valid && in_ready;

  chest_conj_mul u_mul (
    .rx  (rx_c),
    .pil (pil_c),
    .ls  (ls_c)
  );

  always_comb begin
    if (in_sop) begin
      nidx  = '0;
      nuser = '0;
      nmode = in_pilot;
    end else begin
      nmode = s1_pil;
      if (s1_idx == IW'(NSC - 1)) begin
        nidx  = '0;
        nuser = '0;
      end else begin
        nidx  = s1_idx + IW'(1);
        nuser = (s1_user == UW'(NU - 1)) ? '0 : s1_user + UW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_pil  <= 1'b0;
      s1_idx  <= IW'(NSC - 1);
      s1_user <= '0;
      s1_val  <= '0;
    end else begin
      if (in_ready) s1_v <= in_valid;
      if (accept) begin
        s1_idx  <= nidx;
        s1_user <= nuser;
        s1_pil  <= nmode;
        s1_val  <= nmode ? ls_c : rd_c;
      end
    end
  end

  chest_coeff_mem #(.NU(NU), .NSC(NSC), .IW(IW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (s1_take && s1_pil),
    .wr_idx    (s1_idx),
    .wr_val    (s1_val),
    .rd_idx    (nidx),
    .rd_val    (rd_c),
    .first_vec (first_vec)
  );

  chest_zoh_out #(.NU(NU), .NSC(NSC), .IW(IW), .UW(UW)) u_zoh (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_v      (s1_v),
    .s1_pil    (s1_pil),
    .s1_idx    (s1_idx),
    .s1_user   (s1_user),
    .s1_val    (s1_val),
    .first_vec (first_vec),
    .s1_take   (s1_take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sc    (out_sc),
    .out_est   (est)
  );

  for (genvar g = 0; g < NU; g++) begin : g_flat
    assign out_re[g*CW +: CW] = est[g].re;
    assign out_im[g*CW +: CW] = est[g].im;
  end

  AST_USER_OF_SC: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (32'(s1_user) == 32'(s1_idx) % NU)); // R2
endmodule

// File: tb/sim_chest_ls_zoh.sv
`timescale 1ns/1ps
module sim_chest_ls_zoh;
  localparam int NU  = 4;
  localparam int NSC = 16;
  localparam int IW  = $clog2(NSC);
  localparam int CW  = chest_pkg::CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_pilot = 1'b0;
  logic [CW-1:0] in_rx_re = '0, in_rx_im = '0, in_pil_re = '0, in_pil_im = '0;
  logic in_ready, out_valid;
  logic out_ready = 1'b1;
  logic [IW-1:0] out_sc;
  logic [NU*CW-1:0] out_re, out_im;

  always #4 clk = ~clk;

  chest_ls_zoh #(.NU(NU), .NSC(NSC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_pilot(in_pilot), .in_rx_re(in_rx_re), .in_rx_im(in_rx_im),
    .in_pil_re(in_pil_re), .in_pil_im(in_pil_im), .out_valid(out_valid),
    .out_ready(out_ready), .out_sc(out_sc), .out_re(out_re), .out_im(out_im)
  );

  int n_chk = 0, n_err = 0;
  int bp = 0;
  int acc_in_sym = 0;
  bit have_pilot = 0;

  int ref_re [NSC];
  int ref_im [NSC];

  logic [NU*CW-1:0] exp_re_q [$];
  logic [NU*CW-1:0] exp_im_q [$];
  int               exp_sc_q [$];
  bit               exp_pil_q [$];
  string            exp_tag_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R1: conj(pilot) * sample, rounded at bit 14, shifted by 15, clamped
  task automatic ls_ref(input int yr, input int yi, input int pr, input int pi,
                        output int er, output int ei);
    longint sr, si;
    sr = longint'(pr) * yr + longint'(pi) * yi;
    si = longint'(pr) * yi - longint'(pi) * yr;
    er = sat16((sr + 16384) >>> 15);
    ei = sat16((si + 16384) >>> 15);
  endtask

  function automatic int rnd16();
    logic signed [15:0] t;
    t = 16'($urandom);
    return int'(t);
  endfunction

  task automatic send_beat(input bit sop, input bit pil, input int yr, input int yi,
                           input int pr, input int pi);
    bit ok;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sop    = sop;
    in_pilot  = pil;
    in_rx_re  = 16'(yr);
    in_rx_im  = 16'(yi);
    in_pil_re = 16'(pr);
    in_pil_im = 16'(pi);
    forever begin
      #3 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    acc_in_sym = sop ? 1 : acc_in_sym + 1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  // kind 0: random channel, kind 1: arithmetic corner cases on the first beats
  task automatic send_sym(input bit pil, input int kind);
    int yr [NSC]; int yi [NSC]; int pr [NSC]; int pi [NSC];
    int er [NSC]; int ei [NSC];
    for (int k = 0; k < NSC; k++) begin
      yr[k] = rnd16(); yi[k] = rnd16(); pr[k] = rnd16(); pi[k] = rnd16();
    end
    if (kind == 1) begin
      yr[0] = -32768; yi[0] = -32768; pr[0] = -32768; pi[0] = -32768;
      yr[1] = -32768; yi[1] =  32767; pr[1] = -32768; pi[1] =  32767;
      yr[2] =  32767; yi[2] =  32767; pr[2] = -32768; pi[2] = -32768;
      yr[3] =  1;     yi[3] =  0;     pr[3] =  16384; pi[3] =  0;
      yr[4] = -1;     yi[4] =  0;     pr[4] =  16384; pi[4] =  0;
    end
    for (int k = 0; k < NSC; k++) begin
      if (pil) ls_ref(yr[k], yi[k], pr[k], pi[k], er[k], ei[k]);
      else begin er[k] = ref_re[k]; ei[k] = ref_im[k]; end
    end
    for (int k = 0; k < NSC; k++) begin
      logic [NU*CW-1:0] vr, vi;
      string tg;
      for (int u = 0; u < NU; u++) begin
        int src;
        src = (k < NU) ? u : k - ((k - u) % NU);
        vr[u*CW +: CW] = 16'(er[src]);
        vi[u*CW +: CW] = 16'(ei[src]);
      end
      if (pil)             tg = (k < NU) ? "R4" : "R3";
      else if (have_pilot) tg = (k < NU) ? "R4 R5 R11" : "R5 R11";
      else                 tg = "R6 R11";
      if (kind == 1) tg = {tg, " R1"};
      exp_re_q.push_back(vr);
      exp_im_q.push_back(vi);
      exp_sc_q.push_back(k);
      exp_pil_q.push_back(pil);
      exp_tag_q.push_back(tg);
    end
    if (pil) begin
      for (int k = 0; k < NSC; k++) begin ref_re[k] = er[k]; ref_im[k] = ei[k]; end
      have_pilot = 1;
    end
    for (int k = 0; k < NSC; k++) begin
      if (bp != 0 && ($urandom % 4) == 0) idle();
      // R11: pilot flag toggles randomly on non-start beats
      send_beat(k == 0, (k == 0) ? pil : bit'($urandom % 2), yr[k], yi[k], pr[k], pi[k]);
    end
  endtask

  // output monitor: samples mid-cycle, after out_ready has settled
  bit prev_stall = 0;
  logic [IW-1:0] prev_sc;
  logic [NU*CW-1:0] prev_re, prev_im;

  initial begin
    forever begin
      @(negedge clk);
      out_ready <= (bp != 0) ? (($urandom % 3) != 0) : 1'b1;
      #2;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid && out_sc == prev_sc && out_re == prev_re && out_im == prev_im,
                "R8", "stalled output changed", longint'(out_sc), longint'(prev_sc));
        end
        if (out_valid && out_ready) begin
          if (exp_sc_q.size() == 0) begin
            check(1'b0, "R7", "output beat with none expected", longint'(out_sc), -1);
          end else begin
            logic [NU*CW-1:0] vr, vi;
            int sc; bit pl; string tg;
            vr = exp_re_q.pop_front(); vi = exp_im_q.pop_front();
            sc = exp_sc_q.pop_front(); pl = exp_pil_q.pop_front(); tg = exp_tag_q.pop_front();
            check(int'(out_sc) == sc, "R7", "subcarrier index", longint'(out_sc), sc);
            if (pl && sc == 0)
              check(acc_in_sym >= NU, "R9", "pilot output before owner beats", acc_in_sym, NU);
            for (int u = 0; u < NU; u++) begin
              string t2;
              t2 = (pl && sc >= NU && (sc % NU) == u) ? {tg, " R2"} : tg;
              check(out_re[u*CW +: CW] == vr[u*CW +: CW], t2, $sformatf("re sc%0d user%0d", sc, u),
                    longint'($signed(out_re[u*CW +: CW])), longint'($signed(vr[u*CW +: CW])));
              check(out_im[u*CW +: CW] == vi[u*CW +: CW], t2, $sformatf("im sc%0d user%0d", sc, u),
                    longint'($signed(out_im[u*CW +: CW])), longint'($signed(vi[u*CW +: CW])));
            end
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_sc = out_sc; prev_re = out_re; prev_im = out_im;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSC; k++) begin ref_re[k] = 0; ref_im[k] = 0; end
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R10", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R10", "in_ready in reset", longint'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    send_sym(0, 0);
    send_sym(1, 0);
    send_sym(0, 0);
    send_sym(0, 0);
    bp = 1;
    send_sym(1, 1);
    send_sym(0, 0);
    send_sym(1, 0);
    send_sym(0, 0);
    send_sym(0, 0);
    bp = 0;
    for (int r = 0; r < 4; r++) begin
      send_sym(1, 0);
      idle();
      send_sym(0, 0);
    end
    idle();

    for (int w = 0; w < 2000 && exp_sc_q.size() != 0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    check(exp_sc_q.size() == 0, "R7", "missing output beats", exp_sc_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule